// File: doc/BRIEF.md
# Multicycle 16-bit Processor Core

This block is a compact 16-bit processor that runs one instruction at a time over several clock cycles, sharing one memory port for instruction fetches and data accesses. It holds a word-addressed program counter, an instruction register, eight 16-bit general registers and a single ALU. The ALU does the PC increment, address arithmetic, branch comparison and branch target in turn, as well as the arithmetic instructions.

After reset the core fetches from address 0. It fetches, decodes and executes until it meets a halt instruction. It then parks with its status output raised until the next reset. Memory is external with a combinational read path. Writes are taken by the memory on the rising edge in which the write strobe is high.

Instruction word: opcode in bits [15:13]. Register forms put rs in [12:10], rt in [9:7], rd in [6:4] and the function code in [3:0]. Immediate forms put a signed 7-bit offset in [6:0]. The jump form carries a 13-bit target in [12:0].

Top module: `mcpu_core`

## Requirements
- R1: While reset is held and in the first cycle after release, the core drives a read at address 0 with halted low. All eight registers read as zero after reset.
- R2: Opcodes are 0 register op, 1 load, 2 store, 3 branch-if-equal, 4 add-immediate, 5 jump and 7 halt. Opcode 6 changes no register and no memory.
- R3: An opcode 0 instruction writes rd with a function of rs and rt. The function codes are 0 sum, 1 difference (rs minus rt), 2 bitwise and, 3 bitwise or, and 4 signed less-than giving 1 or 0. Function codes 5 to 15 write nothing.
- R4: Add-immediate writes rs plus the sign-extended 7-bit offset into rt.
- R5: Load writes the memory word at rs plus the sign-extended offset into rt.
- R6: Store writes rt to memory at rs plus the sign-extended offset, using one write strobe cycle.
- R7: Branch-if-equal continues at (its own address + 1 + sign-extended offset) when rs equals rt, and at its own address + 1 otherwise. Backward offsets work.
- R8: Jump continues at the 13-bit target, zero-extended to 16 bits.
- R9: After a halt executes, halted stays high and neither strobe is asserted until reset.
- R10: Every instruction takes three cycles (fetch, decode, execute), except branch-if-equal, which takes four. Each fetch reads at the PC, and read and write strobes are never high together.
- R11: Register 0 is an ordinary register; writes to it are kept and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 16 | Word address for fetch, load or store |
| mem_wdata_o | output | 16 | Store data |
| mem_rdata_i | input | 16 | Read data, valid in the same cycle as the address |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| halted_o | output | 1 | High once a halt has executed |

## Verification
The bench runs short programs and reads their results from memory, where store instructions leave them. Several corner cases are targeted:
- A signed less-than on operands whose unsigned order is the reverse catches an unsigned compare.
- A negative store offset and a backward branch loop catch zero-extension of offsets, or a branch taken relative to the wrong PC (which would loop forever or skip the wrong word).
- Unused function codes and a write to register 0 catch a core that writes garbage or treats register 0 as hard-wired zero.
- Cycle counts to halt and a quiet period after halt catch an extra or missing state, or a core that keeps fetching after stopping.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;
  localparam int XLEN   = 16;
  localparam int NREG   = 8;
  localparam int RIDX_W = $clog2(NREG);
  localparam int IMM_W  = 7;
  localparam int JTGT_W = 13;

  localparam logic [2:0] OPC_REG  = 3'd0;
  localparam logic [2:0] OPC_LD   = 3'd1;
  localparam logic [2:0] OPC_ST   = 3'd2;
  localparam logic [2:0] OPC_BEQ  = 3'd3;
  localparam logic [2:0] OPC_ADDI = 3'd4;
  localparam logic [2:0] OPC_JMP  = 3'd5;
  localparam logic [2:0] OPC_HALT = 3'd7;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_BRANCH, ST_HALT
  } cstate_e;

  typedef enum logic [1:0] {
    OPB_ONE, OPB_REG, OPB_IMM
  } opb_sel_e;

  typedef struct packed {
    alu_op_e  alu_op;
    logic     opa_reg;
    opb_sel_e opb_sel;
    logic     pc_ld;
    logic     pc_jmp;
    logic     ir_ld;
    logic     ab_ld;
    logic     flag_ld;
    logic     rf_we;
    logic     rf_dst_rd;
    logic     rf_from_mem;
    logic     mem_rd;
    logic     mem_wr;
    logic     addr_alu;
  } ctrl_t;
endpackage

// File: rtl/mcpu_alu.sv
module mcpu_alu
  import mcpu_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SLT: y_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/mcpu_regfile.sv
module mcpu_regfile #(
  parameter int W  = 16,
  parameter int N  = 8,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_i,
  input  logic [AW-1:0] rb_i,
  output logic [W-1:0]  da_o,
  output logic [W-1:0]  db_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);
  logic [W-1:0] regs_q [N];

  // no hard-wired zero register
  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             regs_q[g] <= '0;
      else if (we_i && wa_i == AW'(g))         regs_q[g] <= wd_i;
    end
  end

  assign da_o = regs_q[ra_i];
  assign db_o = regs_q[rb_i];

  assert_write_lands_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> regs_q[$past(wa_i)] == $past(wd_i));
endmodule

// File: rtl/mcpu_ctrl.sv
module mcpu_ctrl
  import mcpu_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic [2:0] opc_i,
  input  logic [3:0] funct_i,
  input  logic    flag_i,
  output ctrl_t   ctrl_o,
  output cstate_e state_o
);
  cstate_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: state_d = ST_EXEC;
      ST_EXEC:   state_d = (opc_i == OPC_BEQ)  ? ST_BRANCH :
                           (opc_i == OPC_HALT) ? ST_HALT : ST_FETCH;
      ST_BRANCH: state_d = ST_FETCH;
      ST_HALT:   state_d = ST_HALT;
      default:   state_d = ST_FETCH;
    endcase
  end

  always_comb begin
    ctrl_o         = '0;
    ctrl_o.alu_op  = ALU_ADD;
    ctrl_o.opb_sel = OPB_ONE;
    unique case (state_q)
      ST_FETCH: begin
        ctrl_o.mem_rd = 1'b1;
        ctrl_o.ir_ld  = 1'b1;
        ctrl_o.pc_ld  = 1'b1;
      end
      ST_DECODE: ctrl_o.ab_ld = 1'b1;
      ST_EXEC: begin
        ctrl_o.opa_reg = 1'b1;
        ctrl_o.opb_sel = OPB_IMM;
        unique case (opc_i)
          OPC_REG: begin
            ctrl_o.opb_sel   = OPB_REG;
            ctrl_o.rf_dst_rd = 1'b1;
            ctrl_o.rf_we     = (funct_i <= 4'd4);
            unique case (funct_i)
              4'd1:    ctrl_o.alu_op = ALU_SUB;
              4'd2:    ctrl_o.alu_op = ALU_AND;
              4'd3:    ctrl_o.alu_op = ALU_OR;
              4'd4:    ctrl_o.alu_op = ALU_SLT;
              default: ctrl_o.alu_op = ALU_ADD;
            endcase
          end
          OPC_ADDI: ctrl_o.rf_we = 1'b1;
          OPC_LD: begin
            ctrl_o.addr_alu    = 1'b1;
            ctrl_o.mem_rd      = 1'b1;
            ctrl_o.rf_we       = 1'b1;
            ctrl_o.rf_from_mem = 1'b1;
          end
          OPC_ST: begin
            ctrl_o.addr_alu = 1'b1;
            ctrl_o.mem_wr   = 1'b1;
          end
          OPC_BEQ: begin
            ctrl_o.opb_sel = OPB_REG;
            ctrl_o.alu_op  = ALU_SUB;
            ctrl_o.flag_ld = 1'b1;
          end
          OPC_JMP: begin
            ctrl_o.pc_ld  = 1'b1;
            ctrl_o.pc_jmp = 1'b1;
          end
          default: ;
        endcase
      end
      ST_BRANCH: begin
        ctrl_o.opb_sel = OPB_IMM;
        ctrl_o.pc_ld   = flag_i;
      end
      default: ;
    endcase
  end

  assign state_o = state_q;

  assert_halt_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_HALT |=> state_q == ST_HALT);
  assert_beq_extra_cycle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXEC && opc_i == OPC_BEQ) |=> state_q == ST_BRANCH);
endmodule

// File: rtl/mcpu_core.sv
module mcpu_core
  import mcpu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic            halted_o
);
  ctrl_t           ctrl;
  cstate_e         state;
  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q;
  logic            flag_q;
  logic [XLEN-1:0] rf_da, rf_db, rf_wd;
  logic [XLEN-1:0] opa, opb, alu_y, imm_ext, jmp_tgt;
  logic [RIDX_W-1:0] rf_wa;

  assign imm_ext = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign jmp_tgt = {{(XLEN-JTGT_W){1'b0}}, ir_q[JTGT_W-1:0]};

  mcpu_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .opc_i   (ir_q[15:13]),
    .funct_i (ir_q[3:0]),
    .flag_i  (flag_q),
    .ctrl_o  (ctrl),
    .state_o (state)
  );

  assign opa = ctrl.opa_reg ? a_q : pc_q;
  always_comb begin
    unique case (ctrl.opb_sel)
      OPB_REG: opb = b_q;
      OPB_IMM: opb = imm_ext;
      default: opb = XLEN'(1);
    endcase
  end

  mcpu_alu #(.W(XLEN)) u_alu (
    .a_i  (opa),
    .b_i  (opb),
    .op_i (ctrl.alu_op),
    .y_o  (alu_y)
  );

  assign rf_wa = ctrl.rf_dst_rd ? ir_q[6:4] : ir_q[9:7];
  assign rf_wd = ctrl.rf_from_mem ? mem_rdata_i : alu_y;

  mcpu_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_i   (ir_q[12:10]),
    .rb_i   (ir_q[9:7]),
    .da_o   (rf_da),
    .db_o   (rf_db),
    .we_i   (ctrl.rf_we),
    .wa_i   (rf_wa),
    .wd_i   (rf_wd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      ir_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      flag_q <= 1'b0;
    end else begin
      if (ctrl.pc_ld)   pc_q   <= ctrl.pc_jmp ? jmp_tgt : alu_y;
      if (ctrl.ir_ld)   ir_q   <= mem_rdata_i;
      if (ctrl.ab_ld)   begin a_q <= rf_da; b_q <= rf_db; end
      if (ctrl.flag_ld) flag_q <= (alu_y == '0);
    end
  end

  assign mem_addr_o  = ctrl.addr_alu ? alu_y : pc_q;
  assign mem_wdata_o = b_q;
  assign mem_rd_o    = ctrl.mem_rd;
  assign mem_wr_o    = ctrl.mem_wr;
  assign halted_o    = (state == ST_HALT);

  assert_strobe_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));
  assert_fetch_at_pc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_FETCH |-> (mem_rd_o && mem_addr_o == pc_q));
  assert_pc_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_FETCH |=> pc_q == $past(pc_q) + XLEN'(1));
  assert_not_taken_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_BRANCH && !flag_q) |=> pc_q == $past(pc_q));
  assert_halt_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && !mem_rd_o && !mem_wr_o));
endmodule

// File: tb/mcpu_core_test.sv
module mcpu_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int PROG_W     = 64;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr, halted;
  logic [15:0] mem  [256];
  logic [15:0] prog [PROG_W];
  logic        load_go = 1'b0;
  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcpu_core uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .mem_rd_o    (mem_rd),
    .mem_wr_o    (mem_wr),
    .halted_o    (halted)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (load_go) begin
      for (int i = 0; i < 256; i++) mem[i] <= (i < PROG_W) ? prog[i] : 16'h0;
    end else if (mem_wr) begin
      mem[mem_addr[7:0]] <= mem_wdata;
    end
  end

  function automatic logic [15:0] enc_r(int rs, int rt, int rd, int f);
    return {3'd0, 3'(rs), 3'(rt), 3'(rd), 4'(f)};
  endfunction
  function automatic logic [15:0] enc_i(int op, int rs, int rt, int imm);
    return {3'(op), 3'(rs), 3'(rt), 7'(imm)};
  endfunction
  function automatic logic [15:0] enc_j(int t);
    return {3'd5, 13'(t)};
  endfunction
  localparam logic [15:0] HALT = 16'hE000;

  function automatic logic [15:0] ref_r(int f, logic [15:0] x, logic [15:0] y, logic [15:0] old);
    case (f)
      0: return x + y;
      1: return x - y;
      2: return x & y;
      3: return x | y;
      4: return ($signed(x) < $signed(y)) ? 16'd1 : 16'd0;
      default: return old;
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < PROG_W; i++) prog[i] = 16'h0;
  endtask

  task automatic run_prog(int limit, output int cyc);
    rst_ni  = 1'b0;
    load_go = 1'b1;
    @(posedge clk);
    @(negedge clk);
    load_go = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    cyc = 0;
    while (!halted && cyc < limit) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
    if (!halted) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: program did not halt within %0d cycles", limit);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: global timeout");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    logic [15:0] x, y, exp;
    int f;
    void'($urandom(32'd4242));

    // R1: reset state
    clear_prog();
    prog[0] = HALT;
    rst_ni = 1'b0;
    load_go = 1'b1;
    @(posedge clk);
    @(negedge clk);
    load_go = 1'b0;
    check("R1 rd strobe in reset", {15'h0, mem_rd}, 16'h1);
    check("R1 addr in reset", mem_addr, 16'h0);
    rst_ni = 1'b1;
    #1;
    check("R1 first fetch addr", mem_addr, 16'h0);
    check("R1 halted low", {15'h0, halted}, 16'h0);

    // R1: registers zero after reset (r5 stored without writes)
    clear_prog();
    prog[0] = enc_i(2, 0, 5, 50);
    prog[1] = HALT;
    prog[50] = 16'hBEEF;
    run_prog(100, cyc);
    check("R1 reg cleared", mem[50], 16'h0);

    // R3/R5/R6/R10: random register ops on loaded operands
    for (int it = 0; it < 40; it++) begin
      x = 16'($urandom);
      y = 16'($urandom);
      f = $urandom % 5;
      if (it == 0) begin x = 16'hFFFF; y = 16'h0001; f = 4; end
      if (it == 1) begin x = 16'h0001; y = 16'h8000; f = 4; end
      if (it % 7 == 6) f = 5 + ($urandom % 11);
      clear_prog();
      prog[0] = enc_i(1, 0, 1, 40);
      prog[1] = enc_i(1, 0, 2, 41);
      prog[2] = enc_r(1, 2, 3, f);
      prog[3] = enc_i(2, 0, 3, 50);
      prog[4] = HALT;
      prog[40] = x;
      prog[41] = y;
      run_prog(100, cyc);
      exp = ref_r(f, x, y, 16'h0);
      check($sformatf("R3 funct %0d", f), mem[50], exp);
      if (it < 3) check("R10 cycles to halt", 16'(cyc), 16'd15);
    end

    // R4: negative immediate
    clear_prog();
    prog[0] = enc_i(4, 0, 4, -5);
    prog[1] = enc_i(2, 0, 4, 51);
    prog[2] = HALT;
    run_prog(100, cyc);
    check("R4 addi negative", mem[51], 16'hFFFB);

    // R6/R5: negative offset store then load back
    clear_prog();
    prog[0] = enc_i(4, 0, 5, 30);
    prog[1] = enc_i(4, 0, 6, 7);
    prog[2] = enc_i(2, 5, 6, -3);
    prog[3] = enc_i(1, 5, 7, -3);
    prog[4] = enc_i(4, 7, 7, 1);
    prog[5] = enc_i(2, 0, 7, 52);
    prog[6] = HALT;
    run_prog(100, cyc);
    check("R6 store neg offset", mem[27], 16'h0007);
    check("R5 load back", mem[52], 16'h0008);

    // R7: taken forward branch
    clear_prog();
    prog[0] = enc_i(4, 0, 1, 3);
    prog[1] = enc_i(4, 0, 2, 3);
    prog[2] = enc_i(3, 1, 2, 2);
    prog[3] = enc_i(4, 0, 7, 1);
    prog[4] = enc_i(4, 0, 7, 2);
    prog[5] = enc_i(2, 0, 7, 52);
    prog[6] = HALT;
    prog[52] = 16'h1234;
    run_prog(100, cyc);
    check("R7 taken skips", mem[52], 16'h0);
    check("R10 beq extra cycle", 16'(cyc), 16'd16);

    // R7: not taken
    prog[1] = enc_i(4, 0, 2, 4);
    run_prog(100, cyc);
    check("R7 not taken", mem[52], 16'h2);

    // R7: backward loop
    clear_prog();
    prog[0] = enc_i(4, 0, 1, 3);
    prog[1] = enc_i(4, 2, 2, 1);
    prog[2] = enc_i(4, 1, 1, -1);
    prog[3] = enc_i(3, 1, 0, 1);
    prog[4] = enc_i(3, 0, 0, -4);
    prog[5] = enc_i(2, 0, 2, 53);
    prog[6] = HALT;
    run_prog(200, cyc);
    check("R7 backward loop count", mem[53], 16'h3);

    // R8: jump
    clear_prog();
    prog[0] = enc_j(3);
    prog[1] = enc_i(4, 0, 1, 9);
    prog[2] = HALT;
    prog[3] = enc_i(4, 0, 1, 5);
    prog[4] = enc_i(2, 0, 1, 54);
    prog[5] = HALT;
    run_prog(100, cyc);
    check("R8 jump target", mem[54], 16'h5);

    // R11: register 0 writable, used as base
    clear_prog();
    prog[0] = enc_i(4, 0, 0, 12);
    prog[1] = enc_i(2, 0, 0, 0);
    prog[2] = HALT;
    run_prog(100, cyc);
    check("R11 r0 holds write", mem[12], 16'd12);

    // R2: opcode 6 has no effect; R9: halted and quiet
    clear_prog();
    prog[0] = 16'hDFFF;
    prog[1] = enc_i(2, 0, 0, 55);
    prog[2] = HALT;
    prog[3] = enc_i(2, 0, 0, 56);
    prog[55] = 16'hAAAA;
    prog[56] = 16'h5555;
    run_prog(100, cyc);
    check("R2 opcode 6 no write", mem[55], 16'h0);
    check("R9 cycles to halt", 16'(cyc), 16'd9);
    begin
      int bad = 0;
      for (int k = 0; k < 20; k++) begin
        @(posedge clk);
        @(negedge clk);
        if (!halted || mem_rd || mem_wr) bad++;
      end
      check("R9 quiet after halt", 16'(bad), 16'h0);
    end
    check("R9 no execution past halt", mem[56], 16'h5555);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule